// File: doc/BRIEF.md
# 16-bit Word Arithmetic Unit

This unit does the word-wide operations of a small 8-bit processor core. It works on a register pair YA, which holds Y in the high byte and A in the low byte, and on a 16-bit memory word. The memory word arrives as two separate bytes, a low byte and a high byte. For each operation the unit gives back either a new register pair or a new memory word, and it updates the processor status flags N, V, H, Z and C.

To start an operation, the core drives the operation code, the current YA value, the two memory bytes and the page offset of the operand, and pulses `start` for one cycle. All results are registered. They appear together with a one-cycle `done` pulse on the clock after `start`, and they stay unchanged until the next `start`. The unit also supplies the two byte addresses of the operand. The high-byte address is the base offset plus one, and it wraps inside the 256-byte page.

Flags that an operation does not touch keep the value from the last operation that wrote them. The processor core uses this to keep its status word consistent across instruction sequences.

Top module: `ya_word_unit`

## Requirements
- R1: Operation code 0 (add word) loads YA with YA + M, where M = {mem_hi, mem_lo}, with no carry input. C is the carry out of bit 15.
- R2: Operation code 1 (subtract word) loads YA with YA + ~M + 1. C is 1 when no borrow occurs, that is when YA >= M unsigned.
- R3: For add word and subtract word, H is the carry into bit 12 of the sum, and V is the two's-complement overflow of the 16-bit sum. The operand used for both is M for add and ~M with carry-in 1 for subtract.
- R4: Operation code 2 (compare word) forms YA - M and updates only N, Z and C, where C = 1 means no borrow. V, H and word_out keep their values, and ya_out becomes the YA input unchanged.
- R5: Operation code 3 (increment word) and code 4 (decrement word) put M + 1 or M - 1 modulo 2^16 on word_out. The carry or borrow of the low byte is passed into the high byte. mem_wr pulses together with done. Only N and Z change, and ya_out becomes the YA input unchanged.
- R6: Operation code 5 (load word) copies M into YA and sets N and Z from it. V, H, C and word_out are kept.
- R7: For every operation that writes N and Z, Z is 1 only when all 16 result bits are zero, and N equals result bit 15.
- R8: addr_lo equals base_addr, and addr_hi equals base_addr + 1 modulo 256. Both are combinational.
- R9: done is 1 for exactly the one cycle after a cycle with start high. Outside a start, ya_out, word_out and the flags hold their values.
- R10: Operation codes 6 and 7 are reserved. They keep all flags and word_out, do not raise mem_wr, pass the YA input to ya_out, and still produce a done pulse.
- R11: A synchronous active-high reset clears ya_out, word_out, all flags, done and mem_wr to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 inc, 4 dec, 5 load) |
| ya_in | input | 16 | Current register pair, Y high and A low |
| mem_lo | input | 8 | Low byte of the memory word |
| mem_hi | input | 8 | High byte of the memory word |
| base_addr | input | 8 | Page offset of the operand low byte |
| addr_lo | output | 8 | Address of the low byte |
| addr_hi | output | 8 | Address of the high byte, wrapping within the page |
| ya_out | output | 16 | New register pair |
| word_out | output | 16 | New memory word for increment and decrement |
| mem_wr | output | 1 | Pulse requesting write-back of word_out |
| done | output | 1 | Result-valid pulse |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_h | output | 1 | Half-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Several properties are checked on every cycle:
- the start-to-done timing and single-pulse shape of done;
- that outputs hold between operations;
- that compare and the reserved codes leave the pair, the word and the untouched flags alone;
- that increment, decrement and load keep V, H and C;
- that load copies the memory word.

The arithmetic itself is shown only by the bench scenarios. This covers carry, borrow, half-carry at bit 12, signed overflow and full-width zero detection. It also covers the byte-to-byte carry in increment and decrement and the page wrap of the high-byte address. The bench sweeps these over boundary word values and pseudo-random operands and compares each result with values it computes from plain integer arithmetic.

// File: rtl/ywu_pkg.sv
package ywu_pkg;

    typedef enum logic [2:0] {
        OP_ADDW = 3'd0,
        OP_SUBW = 3'd1,
        OP_CMPW = 3'd2,
        OP_INCW = 3'd3,
        OP_DECW = 3'd4,
        OP_LDW  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } ywu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } ywu_flags_t;

    function automatic logic op_is_step(input ywu_op_e o);
        return (o == OP_INCW) || (o == OP_DECW);
    endfunction

    function automatic logic op_is_arith(input ywu_op_e o);
        return (o == OP_ADDW) || (o == OP_SUBW);
    endfunction

    function automatic logic op_negates(input ywu_op_e o);
        return (o == OP_SUBW) || (o == OP_CMPW);
    endfunction

endpackage

// File: rtl/ywu_adder.sv
module ywu_adder #(
    parameter int BYTE_W   = 8,
    parameter int NBYTES   = 2,
    parameter int HALF_BIT = 12,
    localparam int WORD_W  = BYTE_W * NBYTES
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    output logic [WORD_W-1:0] sum,
    output logic              cout,
    output logic              half,
    output logic              ovf
);
    logic [NBYTES:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < NBYTES; i++) begin : g_slice
        logic [BYTE_W:0] part;
        assign part = {1'b0, a[i*BYTE_W +: BYTE_W]}
                    + {1'b0, b[i*BYTE_W +: BYTE_W]}
                    + (BYTE_W+1)'(cy[i]);
        assign sum[i*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
        assign cy[i+1] = part[BYTE_W];
    end

    assign cout = cy[NBYTES];
    assign half = a[HALF_BIT] ^ b[HALF_BIT] ^ sum[HALF_BIT];
    assign ovf  = (a[WORD_W-1] == b[WORD_W-1]) && (sum[WORD_W-1] != a[WORD_W-1]);

endmodule

// File: rtl/ywu_step.sv
module ywu_step #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic              down,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);
    logic [BYTE_W:0]   lo_ext;
    logic [BYTE_W-1:0] lo_addend;
    logic [BYTE_W-1:0] hi_addend;
    logic              lo_carry;

    always_comb begin
        lo_addend = down ? {BYTE_W{1'b1}} : BYTE_W'(1);
        lo_ext    = {1'b0, lo_in} + {1'b0, lo_addend};
        lo_carry  = lo_ext[BYTE_W];
        // Going down, a carry out of the low byte means no borrow.
        if (down)
            hi_addend = lo_carry ? '0 : {BYTE_W{1'b1}};
        else
            hi_addend = BYTE_W'(lo_carry);
        lo_out = lo_ext[BYTE_W-1:0];
        hi_out = hi_in + hi_addend;
    end

endmodule

// File: rtl/ywu_page_addr.sv
module ywu_page_addr #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);
    assign lo_addr = base;
    assign hi_addr = base + ADDR_W'(1);

endmodule

// File: rtl/ya_word_unit.sv
module ya_word_unit #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    localparam int WORD_W   = 2 * BYTE_W,
    localparam int HALF_BIT = BYTE_W + BYTE_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] ya_in,
    input  logic [BYTE_W-1:0] mem_lo,
    input  logic [BYTE_W-1:0] mem_hi,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [WORD_W-1:0] ya_out,
    output logic [WORD_W-1:0] word_out,
    output logic              mem_wr,
    output logic              done,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_h,
    output logic              flag_z,
    output logic              flag_c
);
    import ywu_pkg::*;

    ywu_op_e           op_e;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] add_b;
    logic [WORD_W-1:0] add_sum;
    logic              add_cout;
    logic              add_half;
    logic              add_ovf;
    logic [BYTE_W-1:0] step_lo;
    logic [BYTE_W-1:0] step_hi;
    logic [WORD_W-1:0] step_word;

    logic [WORD_W-1:0] ya_q, ya_d;
    logic [WORD_W-1:0] word_q, word_d;
    ywu_flags_t        flags_q, flags_d;
    logic              done_q, wr_q;

    assign op_e     = ywu_op_e'(op);
    assign mem_word = {mem_hi, mem_lo};
    assign add_b    = op_negates(op_e) ? ~mem_word : mem_word;

    ywu_adder #(
        .BYTE_W  (BYTE_W),
        .NBYTES  (2),
        .HALF_BIT(HALF_BIT)
    ) u_adder (
        .a   (ya_in),
        .b   (add_b),
        .cin (op_negates(op_e)),
        .sum (add_sum),
        .cout(add_cout),
        .half(add_half),
        .ovf (add_ovf)
    );

    ywu_step #(.BYTE_W(BYTE_W)) u_step (
        .lo_in (mem_lo),
        .hi_in (mem_hi),
        .down  (op_e == OP_DECW),
        .lo_out(step_lo),
        .hi_out(step_hi)
    );
    assign step_word = {step_hi, step_lo};

    ywu_page_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base   (base_addr),
        .lo_addr(addr_lo),
        .hi_addr(addr_hi)
    );

    always_comb begin
        ya_d    = ya_in;
        word_d  = word_q;
        flags_d = flags_q;
        unique case (op_e)
            OP_ADDW, OP_SUBW: begin
                ya_d      = add_sum;
                flags_d.n = add_sum[WORD_W-1];
                flags_d.z = ~|add_sum;
                flags_d.c = add_cout;
                flags_d.h = add_half;
                flags_d.v = add_ovf;
            end
            OP_CMPW: begin
                flags_d.n = add_sum[WORD_W-1];
                flags_d.z = ~|add_sum;
                flags_d.c = add_cout;
            end
            OP_INCW, OP_DECW: begin
                word_d    = step_word;
                flags_d.n = step_word[WORD_W-1];
                flags_d.z = ~|step_word;
            end
            OP_LDW: begin
                ya_d      = mem_word;
                flags_d.n = mem_word[WORD_W-1];
                flags_d.z = ~|mem_word;
            end
            default: begin
                ya_d = ya_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ya_q    <= '0;
            word_q  <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            done_q <= start;
            wr_q   <= start && op_is_step(op_e);
            if (start) begin
                ya_q    <= ya_d;
                word_q  <= word_d;
                flags_q <= flags_d;
            end
        end
    end

    assign ya_out   = ya_q;
    assign word_out = word_q;
    assign mem_wr   = wr_q;
    assign done     = done_q;
    assign flag_n   = flags_q.n;
    assign flag_v   = flags_q.v;
    assign flag_h   = flags_q.h;
    assign flag_z   = flags_q.z;
    assign flag_c   = flags_q.c;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R9
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start)); // R9
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(ya_out) && $stable(word_out) && $stable(flags_q))); // R9
    AST_CMP_KEEPS_PAIR: assert property (@(posedge clk) disable iff (rst)
        (start && op_e == OP_CMPW) |=>
            (ya_out == $past(ya_in) && $stable(word_out) && $stable({flag_v, flag_h}))); // R4
    AST_STEP_KEEPS_VHC: assert property (@(posedge clk) disable iff (rst)
        (start && (op_is_step(op_e) || op_e == OP_LDW)) |=> $stable({flag_v, flag_h, flag_c})); // R5
    AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> done); // R5
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        (start && op_e == OP_LDW) |=> (ya_out == $past({mem_hi, mem_lo}))); // R6
    AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (start && !op_is_arith(op_e) && !op_is_step(op_e) && op_e != OP_CMPW && op_e != OP_LDW)
            |=> ($stable(flags_q) && $stable(word_out) && !mem_wr)); // R10

endmodule

// File: tb/sim_ya_word_unit.sv
`timescale 1ns/1ps
module sim_ya_word_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] ya_in = '0;
    logic [7:0]  mem_lo = '0;
    logic [7:0]  mem_hi = '0;
    logic [7:0]  base_addr = '0;
    logic [7:0]  addr_lo, addr_hi;
    logic [15:0] ya_out, word_out;
    logic        mem_wr, done;
    logic        flag_n, flag_v, flag_h, flag_z, flag_c;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // model state
    int m_word = 0;
    int m_n = 0, m_v = 0, m_h = 0, m_z = 0, m_c = 0;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    ya_word_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .ya_in(ya_in),
        .mem_lo(mem_lo), .mem_hi(mem_hi), .base_addr(base_addr),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .ya_out(ya_out),
        .word_out(word_out), .mem_wr(mem_wr), .done(done),
        .flag_n(flag_n), .flag_v(flag_v), .flag_h(flag_h),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic int pat(input int i);
        case (i)
            0: return 'h0000;  1: return 'h0001;  2: return 'h007F;
            3: return 'h0080;  4: return 'h00FF;  5: return 'h0100;
            6: return 'h0FFF;  7: return 'h1000;  8: return 'h7FFF;
            9: return 'h8000; 10: return 'h8001; 11: return 'hFFFF;
           12: return 'hFFFE; 13: return 'hFF00; 14: return 'h0F0F;
           15: return 'hF000; default: return 'h1234;
        endcase
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) & 32'hFFFF);
    endfunction

    function automatic int sgn(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    task automatic do_op(input int o, input int y, input int m);
        int r, e_ya, e_wr, s;
        string rq;
        e_ya = y;
        e_wr = 0;
        case (o)
            0: begin
                rq = "R1/R3/R7";
                r = y + m;
                e_ya = r & 'hFFFF;
                m_c = (r >> 16) & 1;
                m_h = (((y & 'hFFF) + (m & 'hFFF)) >> 12) & 1;
                s = sgn(y) + sgn(m);
                m_v = (s > 32767 || s < -32768) ? 1 : 0;
                m_n = (e_ya >> 15) & 1;
                m_z = (e_ya == 0) ? 1 : 0;
            end
            1: begin
                rq = "R2/R3/R7";
                r = y + ((~m) & 'hFFFF) + 1;
                e_ya = r & 'hFFFF;
                m_c = (y >= m) ? 1 : 0;
                m_h = (((y & 'hFFF) + ((~m) & 'hFFF) + 1) >> 12) & 1;
                s = sgn(y) - sgn(m);
                m_v = (s > 32767 || s < -32768) ? 1 : 0;
                m_n = (e_ya >> 15) & 1;
                m_z = (e_ya == 0) ? 1 : 0;
            end
            2: begin
                rq = "R4/R7";
                r = (y - m) & 'hFFFF;
                m_c = (y >= m) ? 1 : 0;
                m_n = (r >> 15) & 1;
                m_z = (r == 0) ? 1 : 0;
            end
            3, 4: begin
                rq = "R5/R7";
                m_word = (o == 3) ? ((m + 1) & 'hFFFF) : ((m + 'hFFFF) & 'hFFFF);
                e_wr = 1;
                m_n = (m_word >> 15) & 1;
                m_z = (m_word == 0) ? 1 : 0;
            end
            5: begin
                rq = "R6/R7";
                e_ya = m;
                m_n = (m >> 15) & 1;
                m_z = (m == 0) ? 1 : 0;
            end
            default: rq = "R10";
        endcase
        @(negedge clk);
        op = 3'(o);
        ya_in = 16'(y);
        mem_lo = 8'(m & 'hFF);
        mem_hi = 8'((m >> 8) & 'hFF);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "done", int'(done), 1);
        chk(rq, "mem_wr", int'(mem_wr), e_wr);
        chk(rq, "ya_out", int'(ya_out), e_ya);
        chk(rq, "word_out", int'(word_out), m_word);
        chk(rq, "flags nvhzc", int'({flag_n, flag_v, flag_h, flag_z, flag_c}),
            (m_n << 4) | (m_v << 3) | (m_h << 2) | (m_z << 1) | m_c);
    endtask

    task automatic idle_check();
        logic [15:0] ya_s, w_s;
        logic [4:0]  f_s;
        ya_s = ya_out; w_s = word_out;
        f_s = {flag_n, flag_v, flag_h, flag_z, flag_c};
        @(negedge clk);
        chk("R9", "done drops", int'(done), 0);
        chk("R9", "mem_wr drops", int'(mem_wr), 0);
        chk("R9", "ya held", int'(ya_out), int'(ya_s));
        chk("R9", "word held", int'(word_out), int'(w_s));
        chk("R9", "flags held", int'({flag_n, flag_v, flag_h, flag_z, flag_c}), int'(f_s));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "ya_out", int'(ya_out), 0);
        chk("R11", "word_out", int'(word_out), 0);
        chk("R11", "flags", int'({flag_n, flag_v, flag_h, flag_z, flag_c}), 0);
        chk("R11", "done", int'(done), 0);
        chk("R11", "mem_wr", int'(mem_wr), 0);

        // R8: page-wrapped byte addresses, all offsets
        for (int b = 0; b < 256; b++) begin
            base_addr = 8'(b);
            #1;
            chk("R8", "addr_lo", int'(addr_lo), b);
            chk("R8", "addr_hi", int'(addr_hi), (b + 1) & 'hFF);
        end

        // R1 R2 R4: boundary cross products
        for (int o = 0; o < 3; o++)
            for (int i = 0; i < 17; i++)
                for (int j = 0; j < 17; j++)
                    do_op(o, pat(i), pat(j));
        idle_check();

        // R5 R6: increments, decrements and loads over boundaries
        for (int i = 0; i < 17; i++) begin
            do_op(3, pat(16 - i), pat(i));
            do_op(4, pat(i), pat(i));
            do_op(5, pat(i), pat(16 - i));
        end
        idle_check();

        // R10: reserved codes after flags have been set
        do_op(1, 'h0000, 'h0001);
        do_op(6, 'h5A5A, 'h1234);
        do_op(7, 'hA5A5, 'h0000);
        idle_check();

        // pseudo-random mix over all codes
        for (int k = 0; k < 1500; k++) begin
            do_op(k % 8, rnd16(), rnd16());
            if (k % 97 == 0) idle_check();
        end

        // R3: half-carry and overflow corner pairs
        do_op(0, 'h0800, 'h0800);
        do_op(0, 'h7FFF, 'h0001);
        do_op(1, 'h8000, 'h0001);
        do_op(1, 'h1000, 'h0001);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule